// File: doc/BRIEF.md
# Region-Based Sharer Predictor

This block sits beside one core's L2 miss path and remembers, for each recently touched 1 KB memory region, which other core last supplied data for a line in that region. When the L2 misses, the miss address is looked up. If a live entry covers the region, the block names the predicted core and raises a send-direct request. The request then goes cache-to-cache while the directory is told in parallel. If no entry covers the region, no prediction is made and the request goes to the directory alone.

The table is trained by data-response notifications. Each notification carries the address of the line that was filled and the ID of the core that supplied it. A response from another core writes that core's ID into the entry for the line's region. With 64-byte lines, all sixteen lines of a region share one entry. Pair-wise sharing between two cores therefore quickly becomes direct requests.

The table is direct-mapped with 64 entries. Address bits [15:10] select the entry, and bits [31:16] are kept as the tag. Lookups are registered: the outcome of a miss presented in one cycle is on the outputs in the next cycle.

Top module: `region_sharer_pred`

## Requirements
- R1: After rst_ni is released, all three outputs are 0 and every table entry is invalid, so a miss to any address gives no prediction.
- R2: A region is 1 KB. Address bits [15:10] select the entry and bits [31:16] form its tag. Any two miss addresses that differ only in bits [9:0] get the same prediction.
- R3: A response (resp_valid_i high) whose resp_core_i differs from core_id_i writes that entry with valid, the tag of resp_addr_i and resp_core_i. Later misses to that region predict resp_core_i.
- R4: A response whose resp_core_i equals core_id_i leaves the table unchanged. A later miss to that region shows no prediction.
- R5: A miss that hits a valid entry with a matching tag gives pred_valid_o=1 and pred_core_o equal to the stored ID. If that ID is not core_id_i, it also gives send_direct_o=1.
- R6: A miss with no valid entry, or with a tag mismatch, gives pred_valid_o=0, pred_core_o=0 and send_direct_o=0.
- R7: Regions that share index bits [15:10] but differ in tag alias. The latest trained region replaces the earlier one, and a miss to the earlier region then gets no prediction.
- R8: A hit whose stored ID equals core_id_i gives pred_valid_o=1 and pred_core_o equal to that ID, but send_direct_o=0, so the request falls back to the directory.
- R9: A miss and a response to the same entry in the same cycle return the entry's old contents. The update is seen by a miss in the following cycle.
- R10: The outputs reflect the miss of the previous cycle only. In a cycle after which miss_valid_i was low, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| core_id_i | input | 4 | ID of the core that owns this predictor |
| miss_valid_i | input | 1 | L2 miss lookup strobe |
| miss_addr_i | input | 32 | Miss byte address |
| resp_valid_i | input | 1 | Data-response notification strobe |
| resp_addr_i | input | 32 | Byte address of the filled line |
| resp_core_i | input | 4 | ID of the core that supplied the data |
| pred_valid_o | output | 1 | A matching region entry was found |
| pred_core_o | output | 4 | Predicted sharer ID (0 when no prediction) |
| send_direct_o | output | 1 | Send the request straight to pred_core_o |

## Verification
Every result of a miss is due exactly one clock edge after the cycle in which miss_valid_i was high. A response changes the table at that same edge, so its effect first appears for a miss presented one cycle later. The bench drives each stimulus on the falling edge, waits for the next rising edge, and samples the outputs a few nanoseconds after it. Each check is therefore tied to the single edge that registers it. A same-cycle miss and response vector checks the old value, and the vector right after it checks the new one.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int unsigned DEF_ADDR_W    = 32;
  localparam int unsigned DEF_REGION_SZ = 1024;
  localparam int unsigned DEF_ENTRIES   = 64;
  localparam int unsigned DEF_CORES     = 16;

  function automatic int unsigned log2c(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction
endpackage

// File: rtl/rsp_addr_split.sv
module rsp_addr_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 10,
  parameter int unsigned IDX_W  = 6,
  localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic unused_low;
  assign unused_low = ^addr_i[OFF_W-1:0];
  assign idx_o = addr_i[OFF_W +: IDX_W];
  assign tag_o = addr_i[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/rsp_table.sv
module rsp_table #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned TAG_W   = 16,
  parameter int unsigned CORE_W  = 4,
  localparam int unsigned IDX_W  = rsp_pkg::log2c(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_vld_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [CORE_W-1:0] rd_core_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [CORE_W-1:0] wr_core_i
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [CORE_W-1:0]  core_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e]  <= 1'b0;
        tag_q[e]  <= '0;
        core_q[e] <= '0;
      end else if (sel) begin
        vld_q[e]  <= 1'b1;
        tag_q[e]  <= wr_tag_i;
        core_q[e] <= wr_core_i;
      end
    end
  end

  // read sees pre-write contents (R9)
  assign rd_vld_o  = vld_q[rd_idx_i];
  assign rd_tag_o  = tag_q[rd_idx_i];
  assign rd_core_o = core_q[rd_idx_i];

  assert_write_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (vld_q[$past(wr_idx_i)] && tag_q[$past(wr_idx_i)] == $past(wr_tag_i)
                 && core_q[$past(wr_idx_i)] == $past(wr_core_i)));

  assert_quiet_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(vld_q));
endmodule

// File: rtl/rsp_decide.sv
module rsp_decide #(
  parameter int unsigned TAG_W  = 16,
  parameter int unsigned CORE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [TAG_W-1:0]  miss_tag_i,
  input  logic [CORE_W-1:0] core_id_i,
  input  logic              rd_vld_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic [CORE_W-1:0] rd_core_i,
  output logic              pred_valid_o,
  output logic [CORE_W-1:0] pred_core_o,
  output logic              send_direct_o
);
  logic hit;
  assign hit = miss_valid_i && rd_vld_i && (rd_tag_i == miss_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_o  <= 1'b0;
      pred_core_o   <= '0;
      send_direct_o <= 1'b0;
    end else begin
      pred_valid_o  <= hit;
      pred_core_o   <= hit ? rd_core_i : '0;
      send_direct_o <= hit && (rd_core_i != core_id_i);
    end
  end

  assert_direct_needs_pred_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_direct_o |-> pred_valid_o);

  assert_no_self_direct_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_direct_o |-> (pred_core_o != $past(core_id_i)));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_valid_i |=> (!pred_valid_o && !send_direct_o));

  assert_core_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_o |-> (pred_core_o == '0));
endmodule

// File: rtl/region_sharer_pred.sv
module region_sharer_pred #(
  parameter int unsigned ADDR_W    = rsp_pkg::DEF_ADDR_W,
  parameter int unsigned REGION_SZ = rsp_pkg::DEF_REGION_SZ,
  parameter int unsigned ENTRIES   = rsp_pkg::DEF_ENTRIES,
  parameter int unsigned CORES     = rsp_pkg::DEF_CORES,
  localparam int unsigned OFF_W    = rsp_pkg::log2c(REGION_SZ),
  localparam int unsigned IDX_W    = rsp_pkg::log2c(ENTRIES),
  localparam int unsigned TAG_W    = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned CORE_W   = rsp_pkg::log2c(CORES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CORE_W-1:0] core_id_i,
  input  logic              miss_valid_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic              resp_valid_i,
  input  logic [ADDR_W-1:0] resp_addr_i,
  input  logic [CORE_W-1:0] resp_core_i,
  output logic              pred_valid_o,
  output logic [CORE_W-1:0] pred_core_o,
  output logic              send_direct_o
);
  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag, rd_tag;
  logic              rd_vld, wr_en;
  logic [CORE_W-1:0] rd_core;

  rsp_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_lk_split (
    .addr_i(miss_addr_i), .idx_o(lk_idx), .tag_o(lk_tag));

  rsp_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_up_split (
    .addr_i(resp_addr_i), .idx_o(up_idx), .tag_o(up_tag));

  // own-core responses do not train (R4)
  assign wr_en = resp_valid_i && (resp_core_i != core_id_i);

  rsp_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .CORE_W(CORE_W)) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_idx_i(lk_idx), .rd_vld_o(rd_vld), .rd_tag_o(rd_tag), .rd_core_o(rd_core),
    .wr_en_i(wr_en), .wr_idx_i(up_idx), .wr_tag_i(up_tag), .wr_core_i(resp_core_i));

  rsp_decide #(.TAG_W(TAG_W), .CORE_W(CORE_W)) u_decide (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .miss_valid_i(miss_valid_i), .miss_tag_i(lk_tag), .core_id_i(core_id_i),
    .rd_vld_i(rd_vld), .rd_tag_i(rd_tag), .rd_core_i(rd_core),
    .pred_valid_o(pred_valid_o), .pred_core_o(pred_core_o), .send_direct_o(send_direct_o));

  assert_self_resp_no_train_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_i && resp_core_i == core_id_i) |-> !wr_en);
endmodule

// File: tb/sim_region_sharer_pred.sv
module sim_region_sharer_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  core_id;
  logic        miss_v, resp_v;
  logic [31:0] miss_a, resp_a;
  logic [3:0]  resp_c;
  logic        pred_v, direct;
  logic [3:0]  pred_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  region_sharer_pred u0 (
    .clk_i(clk), .rst_ni(rst_n), .core_id_i(core_id),
    .miss_valid_i(miss_v), .miss_addr_i(miss_a),
    .resp_valid_i(resp_v), .resp_addr_i(resp_a), .resp_core_i(resp_c),
    .pred_valid_o(pred_v), .pred_core_o(pred_c), .send_direct_o(direct));

  typedef struct packed {
    logic [7:0]  req;
    logic        mv;
    logic [31:0] ma;
    logic        rv;
    logic [31:0] ra;
    logic [3:0]  rc;
    logic        ev;
    logic [3:0]  ec;
    logic        ed;
  } vec_t;

  localparam int NV = 13;
  // core_id = 3 throughout the table
  localparam vec_t VECS [NV] = '{
    '{8'd6,  1'b1, 32'h0000_1400, 1'b0, 32'h0,          4'h0, 1'b0, 4'h0, 1'b0}, // R6 empty
    '{8'd3,  1'b0, 32'h0,          1'b1, 32'h0000_1440, 4'h5, 1'b0, 4'h0, 1'b0}, // R3 train
    '{8'd2,  1'b1, 32'h0000_17C0, 1'b0, 32'h0,          4'h0, 1'b1, 4'h5, 1'b1}, // R2 other line
    '{8'd5,  1'b1, 32'h0000_1400, 1'b0, 32'h0,          4'h0, 1'b1, 4'h5, 1'b1}, // R5 hit
    '{8'd4,  1'b0, 32'h0,          1'b1, 32'h0000_2000, 4'h3, 1'b0, 4'h0, 1'b0}, // R4 self resp
    '{8'd4,  1'b1, 32'h0000_2000, 1'b0, 32'h0,          4'h0, 1'b0, 4'h0, 1'b0}, // R4 ignored
    '{8'd7,  1'b1, 32'h0001_1400, 1'b0, 32'h0,          4'h0, 1'b0, 4'h0, 1'b0}, // R7 tag miss
    '{8'd9,  1'b1, 32'h0001_1400, 1'b1, 32'h0001_1400, 4'h9, 1'b0, 4'h0, 1'b0}, // R9 old value
    '{8'd9,  1'b1, 32'h0001_17FC, 1'b0, 32'h0,          4'h0, 1'b1, 4'h9, 1'b1}, // R9 new value
    '{8'd7,  1'b1, 32'h0000_1400, 1'b0, 32'h0,          4'h0, 1'b0, 4'h0, 1'b0}, // R7 evicted
    '{8'd3,  1'b0, 32'h0,          1'b1, 32'h0000_1800, 4'hF, 1'b0, 4'h0, 1'b0}, // R3 train F
    '{8'd2,  1'b1, 32'h0000_1BFF, 1'b0, 32'h0,          4'h0, 1'b1, 4'hF, 1'b1}, // R2 top byte
    '{8'd2,  1'b1, 32'h0000_1C00, 1'b0, 32'h0,          4'h0, 1'b0, 4'h0, 1'b0}  // R2 next region
  };

  task automatic check(input string tag, input logic ev, input logic [3:0] ec, input logic ed);
    checks++;
    if (pred_v !== ev || pred_c !== ec || direct !== ed) begin
      fails++;
      $display("FAIL %s: got valid=%b core=%h direct=%b exp valid=%b core=%h direct=%b",
               tag, pred_v, pred_c, direct, ev, ec, ed);
    end
  endtask

  task automatic step(input logic mv, input logic [31:0] ma, input logic rv,
                      input logic [31:0] ra, input logic [3:0] rc);
    @(negedge clk);
    miss_v = mv; miss_a = ma; resp_v = rv; resp_a = ra; resp_c = rc;
    @(posedge clk);
    #5;
  endtask

  initial begin
    core_id = 4'h3; miss_v = 0; miss_a = '0; resp_v = 0; resp_a = '0; resp_c = '0;
    repeat (3) @(posedge clk);
    #5;
    check("R1 during reset", 1'b0, 4'h0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, 32'h0000_0000, 1'b0, '0, '0);
    check("R1 after reset", 1'b0, 4'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].mv, VECS[i].ma, VECS[i].rv, VECS[i].ra, VECS[i].rc);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].ev, VECS[i].ec, VECS[i].ed);
    end

    // R10: no miss -> outputs drop although last miss hit
    step(1'b1, 32'h0001_1400, 1'b0, '0, '0);
    check("R10 hit before idle", 1'b1, 4'h9, 1'b1);
    step(1'b0, 32'h0001_1400, 1'b0, '0, '0);
    check("R10 idle", 1'b0, 4'h0, 1'b0);

    // R8: owner becomes core 9; entry naming 9 is suppressed
    core_id = 4'h9;
    step(1'b1, 32'h0001_1400, 1'b0, '0, '0);
    check("R8 self suppressed", 1'b1, 4'h9, 1'b0);
    core_id = 4'h3;
    step(1'b1, 32'h0001_1400, 1'b0, '0, '0);
    check("R8 restored", 1'b1, 4'h9, 1'b1);

    // R1: reset mid-run clears the table
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, 32'h0001_1400, 1'b0, '0, '0);
    check("R1 table cleared", 1'b0, 4'h0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule